// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block converts six asynchronous external interrupt pins into request lines for the priority arbiter of a small microcontroller core. Four general pins each take a two-bit trigger mode: active-low level, rising edge, falling edge, or either edge. Two legacy pins take a single edge-enable bit. When that bit is set, legacy pin 0 responds to a falling edge only and legacy pin 1 responds to both edges, so that software can time the width of a pulse.

Each pin passes through a multi-flop synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. In the edge modes a detected edge sets a sticky flag. The flag stays set until that source is cleared by its acknowledge or by software, through one clear strobe per source. In level mode the request simply mirrors the inverted synchronised pin. Any change to a channel's trigger selection drops a pending edge flag, so a reconfiguration cannot leave a stale request behind.

Top module: `extirq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, every request output is 0. The synchronisers reset to the idle-high pin state.
- R2: In level mode (general mode field 2'b00, or legacy edge-enable bit 0), the request is 1 exactly while the synchronised pin is 0. It appears 2 clock edges after the pin change and is never latched.
- R3: In rising mode (field 2'b01), a 0-to-1 pin change sets the request 3 edges later. A 1-to-0 change does not set it.
- R4: In falling mode (field 2'b10), a 1-to-0 pin change sets the request 3 edges later. A 0-to-1 change does not set it.
- R5: In both-edge mode (field 2'b11), any pin change sets the request 3 edges later.
- R6: An edge-mode request stays set until its clear strobe is sampled high. It is then 0 after that edge. A clear has no effect on a level-mode request.
- R7: If a new edge is detected at the same edge that samples a clear, the request stays set.
- R8: A change of a channel's effective trigger mode clears its pending edge flag at the next edge, regardless of any edge detected in that cycle.
- R9: Legacy pin 0 (req_leg[0]) with its edge-enable bit set responds to 1-to-0 changes only.
- R10: Legacy pin 1 (req_leg[1]) with its edge-enable bit set responds to both 1-to-0 and 0-to-1 changes.
- R11: General channel g uses bits [2g+1:2g] of mode_gen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_gen | input | NUM_GEN | Raw asynchronous general interrupt pins |
| mode_gen | input | 2*NUM_GEN | Two-bit trigger mode per general pin |
| clr_gen | input | NUM_GEN | One-cycle clear strobe per general source |
| pin_leg | input | 2 | Raw asynchronous legacy interrupt pins |
| edge_leg | input | 2 | Legacy edge enable (1 = edge, 0 = level) |
| clr_leg | input | 2 | One-cycle clear strobe per legacy source |
| req_gen | output | NUM_GEN | Request lines of the general sources |
| req_leg | output | 2 | Request lines of the legacy sources |

## Verification
The assertions check four things on every cycle. A level-mode channel never holds a latched flag. A flag only rises after a sampled pin change. A flag persists until it is cleared or its mode changes. A mode change or an edge-free clear empties the flag at the next edge. Only the bench's scenarios can show the rest: the exact latencies from pin to request, which direction each mode reacts to, the fixed edge behaviour of the two legacy pins, and that a clear coinciding with an edge loses nothing.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    parameter int NUM_GEN     = 4;
    parameter int NUM_LEG     = 2;
    parameter int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_mode_e;

    // True when the sampled transition prv -> cur matches the mode.
    function automatic logic edge_hit(trig_mode_e m, logic cur, logic prv);
        case (m)
            TRIG_RISE: edge_hit = cur & ~prv;
            TRIG_FALL: edge_hit = ~cur & prv;
            TRIG_BOTH: edge_hit = cur ^ prv;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

    // Legacy channels map their single bit onto a fixed edge mode.
    function automatic trig_mode_e legacy_mode(logic edge_en, trig_mode_e edge_kind);
        legacy_mode = edge_en ? edge_kind : TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] stg [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '1;
                    else     stg[s] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '1;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
    assign prev_o = stg[STAGES];

    // R1: leaving reset, the synchronised view is the idle-high pin state
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (&sync_o && &prev_o));

endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
    import extirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       prev_i,
    input  trig_mode_e mode_i,
    input  logic       clr_i,
    output logic       req_o
);
    trig_mode_e mode_q;
    logic       flag_q;
    logic       hit;

    assign hit = edge_hit(mode_i, sync_i, prev_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TRIG_LEVEL;
            flag_q <= 1'b0;
        end else begin
            mode_q <= mode_i;
            if (mode_i != mode_q) flag_q <= 1'b0;
            else if (hit)         flag_q <= 1'b1;
            else if (clr_i)       flag_q <= 1'b0;
        end
    end

    always_comb begin
        if (mode_i == TRIG_LEVEL) req_o = ~sync_i;
        else                      req_o = flag_q;
    end

    // R2: a channel settled in level mode holds no latched flag
    p_level_unlatched_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TRIG_LEVEL && mode_q == TRIG_LEVEL) |-> !flag_q);

    // R3: a flag only rises after the synchroniser showed a transition
    p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(sync_i != prev_i));

    // R6: without clear or mode change the flag persists
    p_flag_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i && mode_i == mode_q) |=> flag_q);

    // R6: a clear with no coincident transition empties the flag
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && sync_i == prev_i) |=> !flag_q);

    // R8: any mode change empties the flag at the next edge
    p_mode_change_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_i != mode_q) |=> !flag_q);

endmodule

// File: rtl/extirq_top.sv
module extirq_top
    import extirq_pkg::*;
#(
    parameter int NG = NUM_GEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NG-1:0]   pin_gen,
    input  logic [2*NG-1:0] mode_gen,
    input  logic [NG-1:0]   clr_gen,
    input  logic [1:0]      pin_leg,
    input  logic [1:0]      edge_leg,
    input  logic [1:0]      clr_leg,
    output logic [NG-1:0]   req_gen,
    output logic [1:0]      req_leg
);
    localparam int NCH = NG + NUM_LEG;

    logic [NCH-1:0] pins_all, clr_all, req_all, sync_all, prev_all;
    trig_mode_e     ch_mode [NCH];

    assign pins_all = {pin_leg, pin_gen};
    assign clr_all  = {clr_leg, clr_gen};

    always_comb begin
        for (int g = 0; g < NG; g++)
            ch_mode[g] = trig_mode_e'(mode_gen[2*g +: 2]);
        // R9: legacy 0 edge mode is falling only
        ch_mode[NG]   = legacy_mode(edge_leg[0], TRIG_FALL);
        // R10: legacy 1 edge mode takes both directions
        ch_mode[NG+1] = legacy_mode(edge_leg[1], TRIG_BOTH);
    end

    extirq_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pins_all),
        .sync_o (sync_all),
        .prev_o (prev_all)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            extirq_chan u_chan (
                .clk    (clk),
                .rst    (rst),
                .sync_i (sync_all[c]),
                .prev_i (prev_all[c]),
                .mode_i (ch_mode[c]),
                .clr_i  (clr_all[c]),
                .req_o  (req_all[c])
            );
        end
    endgenerate

    assign req_gen = req_all[NG-1:0];
    assign req_leg = req_all[NCH-1:NG];

endmodule

// File: tb/extirq_top_test.sv
module extirq_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_gen = 4'hF;
    logic [7:0] mode_gen = 8'h00;
    logic [3:0] clr_gen = 4'h0;
    logic [1:0] pin_leg = 2'b11;
    logic [1:0] edge_leg = 2'b00;
    logic [1:0] clr_leg = 2'b00;
    logic [3:0] req_gen;
    logic [1:0] req_leg;
    logic [5:0] req_all;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int    due;
        int    idx;
        bit    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    extirq_top uut (
        .clk(clk), .rst(rst),
        .pin_gen(pin_gen), .mode_gen(mode_gen), .clr_gen(clr_gen),
        .pin_leg(pin_leg), .edge_leg(edge_leg), .clr_leg(clr_leg),
        .req_gen(req_gen), .req_leg(req_leg)
    );

    assign req_all = {req_leg, req_gen};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_req(int lat, int idx, bit val, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.idx = idx;
        e.val = val;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares due scoreboard entries away from the active edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                checks++;
                if (req_all[sb[i].idx] !== sb[i].val || sb[i].due != cyc) begin
                    errors++;
                    $display("FAIL %s ch%0d at cycle %0d: actual %b expected %b",
                             sb[i].tag, sb[i].idx, cyc, req_all[sb[i].idx], sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        for (int c = 0; c < 6; c++) expect_req(0, c, 1'b0, "R1");
        rst = 1'b0;
        for (int c = 0; c < 6; c++) expect_req(1, c, 1'b0, "R1");
        tick();
        // R11 placement: gen0 rise, gen1 fall, gen2 both, gen3 level
        mode_gen = {2'b00, 2'b11, 2'b10, 2'b01};
        edge_leg = 2'b11;
        repeat (3) tick();

        // Falling transition on every pin
        pin_gen = 4'h0; pin_leg = 2'b00;
        expect_req(2, 3, 1'b1, "R2");
        expect_req(1, 3, 1'b0, "R2");
        expect_req(3, 0, 1'b0, "R3");
        expect_req(2, 1, 1'b0, "R4");
        expect_req(3, 1, 1'b1, "R4");
        expect_req(3, 2, 1'b1, "R5");
        expect_req(3, 4, 1'b1, "R9");
        expect_req(3, 5, 1'b1, "R10");
        repeat (5) tick();
        expect_req(1, 1, 1'b1, "R6");
        tick();

        // Clear edge flags; level channel unaffected
        clr_gen = 4'b1110; clr_leg = 2'b11;
        expect_req(1, 1, 1'b0, "R6");
        expect_req(1, 2, 1'b0, "R6");
        expect_req(1, 3, 1'b1, "R6");
        expect_req(1, 4, 1'b0, "R6");
        expect_req(1, 5, 1'b0, "R6");
        tick();
        clr_gen = 4'h0; clr_leg = 2'b00;
        repeat (2) tick();

        // Rising transition on every pin
        pin_gen = 4'hF; pin_leg = 2'b11;
        expect_req(3, 0, 1'b1, "R3");
        expect_req(3, 1, 1'b0, "R4");
        expect_req(3, 2, 1'b1, "R5");
        expect_req(2, 3, 1'b0, "R2");
        expect_req(3, 4, 1'b0, "R9");
        expect_req(3, 5, 1'b1, "R10");
        repeat (4) tick();
        clr_gen = 4'hF; clr_leg = 2'b11;
        for (int c = 0; c < 6; c++) expect_req(1, c, 1'b0, "R6");
        tick();
        clr_gen = 4'h0; clr_leg = 2'b00;
        repeat (2) tick();

        // R7: clear coinciding with a new edge on gen2
        pin_gen[2] = 1'b0;
        expect_req(3, 2, 1'b1, "R7");
        expect_req(4, 2, 1'b1, "R7");
        repeat (2) tick();
        clr_gen[2] = 1'b1;
        tick();
        clr_gen[2] = 1'b0;
        repeat (3) tick();

        // R8: pending flag on gen1 dropped by a mode change
        pin_gen[1] = 1'b0;
        expect_req(3, 1, 1'b1, "R4");
        repeat (4) tick();
        mode_gen[3:2] = 2'b11;
        expect_req(1, 1, 1'b0, "R8");
        expect_req(3, 1, 1'b0, "R8");
        repeat (4) tick();

        // R9: legacy 0 back in level mode
        edge_leg[0] = 1'b0;
        expect_req(1, 4, 1'b0, "R9");
        tick();
        pin_leg[0] = 1'b0;
        expect_req(2, 4, 1'b1, "R2");
        repeat (3) tick();
        pin_leg[0] = 1'b1;
        expect_req(2, 4, 1'b0, "R2");
        repeat (6) tick();

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule